// File: doc/BRIEF.md
# Parallel Port Pin Multiplexer

This block controls a port of parallel I/O pins. Two 16-bit configuration registers sit on a simple register bus: a mode register and a direction register. Together they decide, for each pin, one of four roles: general-purpose input, general-purpose output, peripheral function 0 or peripheral function 1. The pin-level data register, interrupt logic and the peripherals themselves are outside the block and connect through plain signal ports.

The direction bit has two meanings. On a general-purpose pin it sets the drive direction. On a pin dedicated to a peripheral it picks which of the two peripheral functions owns the pin. Each pin's output enable and output value come from the GPIO output data or from the selected peripheral. The pin's input value is passed only to the selected peripheral input. A peripheral input whose pin is in GPIO mode is held at 0; on the last pin this grounds a serial receive-data input. A per-pin open-drain capability flag is exported as a constant mask. The last pin has no open-drain capability.

Both registers clear on the hard reset and keep their contents through the soft reset.

Top module: `pio_pin_mux`

## Requirements
- R1: While `hrst` is high at a clock edge, both registers clear to 0, so every pin becomes a general-purpose input with `pin_oe` = 0.
- R2: The soft reset `srst` leaves both registers unchanged. A bus write in the same cycle as `srst` still takes effect.
- R3: When `hrst` and a bus write arrive in the same cycle, the hard reset wins and both registers read 0 afterwards.
- R4: Mode bit 0 makes a pin general-purpose. With direction bit 0 the pin is an input (`pin_oe` = 0). With direction bit 1 the pin is an output: `pin_oe` = 1 and `pin_dout` = `gpio_dout` of that pin.
- R5: Mode bit 1 dedicates a pin to a peripheral. Direction bit 0 drives `pin_oe`/`pin_dout` from `pf0_oe`/`pf0_dout`, and direction bit 1 drives them from `pf1_oe`/`pf1_dout`.
- R6: A dedicated pin feeds `pin_din` to the selected function's input (`pf0_din` or `pf1_din`); the other function's input is 0. A GPIO pin forces both peripheral inputs to 0, including the receive input on pin 15.
- R7: Bit numbering is big-endian. Register data bit `15-p` (counted LSB = 0 on the bus) controls pin `p`. All pin-level port vectors are indexed so that bit `p` is pin `p`.
- R8: The direction register is at offset 0x950 and the mode register at 0x952. A write (`bus_sel` = 1, `bus_wr` = 1) updates the register at the clock edge. A read (`bus_sel` = 1, `bus_wr` = 0) returns its contents on `bus_rdata` in the same cycle. `bus_rdata` is 0 when no read is in progress.
- R9: A write to any other offset changes no register, and a read from any other offset returns 0.
- R10: `pin_od_cap` is a constant mask with bit `p` set for each pin capable of open-drain drive. By default all pins except pin 15 are capable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst | input | 1 | Hard reset, synchronous, active high; clears the registers |
| srst | input | 1 | Soft reset; registers keep their contents |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register offset |
| bus_wdata | input | 16 | Write data, bus order |
| bus_rdata | output | 16 | Read data, bus order, same cycle |
| gpio_dout | input | 16 | GPIO output value per pin |
| pf0_oe | input | 16 | Peripheral function 0 output enable per pin |
| pf0_dout | input | 16 | Peripheral function 0 output value per pin |
| pf1_oe | input | 16 | Peripheral function 1 output enable per pin |
| pf1_dout | input | 16 | Peripheral function 1 output value per pin |
| pin_din | input | 16 | Value sampled on each pin |
| pin_oe | output | 16 | Output enable per pin |
| pin_dout | output | 16 | Output value per pin |
| pf0_din | output | 16 | Pin input routed to peripheral function 0 |
| pf1_din | output | 16 | Pin input routed to peripheral function 1 |
| pin_od_cap | output | 16 | Open-drain capability flag per pin |

## Verification
Two pairs of functions can meet in one clock cycle. A register write can coincide with the soft reset, and it can coincide with the hard reset. The bench provokes both cases directly and also lets random `srst` pulses overlap random writes. Afterwards it reads the registers back and compares the pin outputs. A write that meets `srst` must land. A write that meets `hrst` must leave both registers at 0.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    PM_GPIO_IN  = 2'd0,
    PM_GPIO_OUT = 2'd1,
    PM_PERIPH0  = 2'd2,
    PM_PERIPH1  = 2'd3
  } pin_mode_e;

  // mode bit selects GPIO/peripheral, direction bit refines it
  function automatic pin_mode_e decode_mode(input logic dedicated, input logic dir);
    pin_mode_e m;
    case ({dedicated, dir})
      2'b00:   m = PM_GPIO_IN;
      2'b01:   m = PM_GPIO_OUT;
      2'b10:   m = PM_PERIPH0;
      default: m = PM_PERIPH1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs #(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] DIR_OFS = 12'h950,
  parameter logic [ADDR_W-1:0] MODE_OFS = 12'h952
) (
  input  logic              clk,
  input  logic              hrst,
  input  logic              srst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic [NPINS-1:0]  dir_pin,
  output logic [NPINS-1:0]  mode_pin
);

  localparam int MSB = NPINS - 1;

  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] mode_q;
  logic             wr_en, rd_en, hit_dir, hit_mode;

  assign wr_en    = bus_sel & bus_wr;
  assign rd_en    = bus_sel & ~bus_wr;
  assign hit_dir  = (bus_addr == DIR_OFS);
  assign hit_mode = (bus_addr == MODE_OFS);

  // only the hard reset clears the configuration
  always_ff @(posedge clk) begin
    if (hrst) begin
      dir_q  <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      if (hit_dir)  dir_q  <= bus_wdata;
      if (hit_mode) mode_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (hit_dir)       bus_rdata = dir_q;
      else if (hit_mode) bus_rdata = mode_q;
    end
  end

  // bus bit 0 (MSB in big-endian numbering) maps to pin 0
  for (genvar p = 0; p < NPINS; p++) begin : g_map
    assign dir_pin[p]  = dir_q[MSB-p];
    assign mode_pin[p] = mode_q[MSB-p];
  end

  // R1 / R3: hard reset clears, even against a concurrent write
  a_r3_hrst_clears: assert property (@(posedge clk)
    hrst |=> (dir_q == '0) && (mode_q == '0));

  // R2: soft reset without a write leaves contents alone
  a_r2_srst_holds: assert property (@(posedge clk) disable iff (hrst)
    (srst && !wr_en) |=> $stable(dir_q) && $stable(mode_q));

  // R9: writes elsewhere touch nothing
  a_r9_stray_write: assert property (@(posedge clk) disable iff (hrst)
    (wr_en && !hit_dir && !hit_mode) |=> $stable(dir_q) && $stable(mode_q));

  // R8: a write to the direction offset lands, mode register untouched
  a_r8_dir_write: assert property (@(posedge clk) disable iff (hrst)
    (wr_en && hit_dir) |=> (dir_q == $past(bus_wdata)) && $stable(mode_q));

endmodule

// File: rtl/pio_pin_cell.sv
module pio_pin_cell
  import pio_pkg::*;
(
  input  logic clk,
  input  logic hrst,
  input  logic dedicated,
  input  logic dir,
  input  logic gpio_do,
  input  logic f0_oe,
  input  logic f0_do,
  input  logic f1_oe,
  input  logic f1_do,
  input  logic pin_di,
  output logic oe,
  output logic dout,
  output logic f0_di,
  output logic f1_di
);

  pin_mode_e mode;

  assign mode = decode_mode(dedicated, dir);

  always_comb begin
    oe    = 1'b0;
    dout  = 1'b0;
    f0_di = 1'b0;
    f1_di = 1'b0;
    case (mode)
      PM_GPIO_IN:  ;
      PM_GPIO_OUT: begin
        oe   = 1'b1;
        dout = gpio_do;
      end
      PM_PERIPH0: begin
        oe    = f0_oe;
        dout  = f0_do;
        f0_di = pin_di;
      end
      default: begin
        oe    = f1_oe;
        dout  = f1_do;
        f1_di = pin_di;
      end
    endcase
  end

  // R6: a GPIO pin grounds both peripheral inputs
  a_r6_gpio_grounds: assert property (@(posedge clk) disable iff (hrst)
    !dedicated |-> (f0_di == 1'b0) && (f1_di == 1'b0));

  // R5: function 1 owns the pin when selected
  a_r5_func1_owns: assert property (@(posedge clk) disable iff (hrst)
    (dedicated && dir) |-> (oe == f1_oe) && (dout == f1_do) && (f0_di == 1'b0));

  // R4: GPIO input never drives
  a_r4_gpio_in_quiet: assert property (@(posedge clk) disable iff (hrst)
    (!dedicated && !dir) |-> !oe);

endmodule

// File: rtl/pio_pin_mux.sv
module pio_pin_mux #(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] DIR_OFS  = 12'h950,
  parameter logic [ADDR_W-1:0] MODE_OFS = 12'h952,
  parameter logic [NPINS-1:0]  OD_MASK  = 16'h7FFF
) (
  input  logic              clk,
  input  logic              hrst,
  input  logic              srst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  gpio_dout,
  input  logic [NPINS-1:0]  pf0_oe,
  input  logic [NPINS-1:0]  pf0_dout,
  input  logic [NPINS-1:0]  pf1_oe,
  input  logic [NPINS-1:0]  pf1_dout,
  input  logic [NPINS-1:0]  pin_din,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_dout,
  output logic [NPINS-1:0]  pf0_din,
  output logic [NPINS-1:0]  pf1_din,
  output logic [NPINS-1:0]  pin_od_cap
);

  logic [NPINS-1:0] dir_pin;
  logic [NPINS-1:0] mode_pin;

  pio_cfg_regs #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .DIR_OFS(DIR_OFS), .MODE_OFS(MODE_OFS)
  ) u_regs (
    .clk(clk), .hrst(hrst), .srst(srst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dir_pin(dir_pin), .mode_pin(mode_pin)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pio_pin_cell u_cell (
      .clk(clk), .hrst(hrst),
      .dedicated(mode_pin[p]), .dir(dir_pin[p]),
      .gpio_do(gpio_dout[p]),
      .f0_oe(pf0_oe[p]), .f0_do(pf0_dout[p]),
      .f1_oe(pf1_oe[p]), .f1_do(pf1_dout[p]),
      .pin_di(pin_din[p]),
      .oe(pin_oe[p]), .dout(pin_dout[p]),
      .f0_di(pf0_din[p]), .f1_di(pf1_din[p])
    );
  end

  assign pin_od_cap = OD_MASK;

  // R9: reads of unmapped offsets return zero
  a_r9_unmapped_read: assert property (@(posedge clk) disable iff (hrst)
    (bus_sel && !bus_wr && bus_addr != DIR_OFS && bus_addr != MODE_OFS)
      |-> (bus_rdata == '0));

  // R8: idle bus reads as zero
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (hrst)
    !bus_sel |-> (bus_rdata == '0));

endmodule

// File: tb/sim_pio_pin_mux.sv
`timescale 1ns/1ps
module sim_pio_pin_mux;

  localparam int N = 16;
  localparam logic [11:0] A_DIR  = 12'h950;
  localparam logic [11:0] A_MODE = 12'h952;

  logic clk = 1'b0;
  logic hrst, srst, bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [N-1:0] bus_wdata, bus_rdata;
  logic [N-1:0] gpio_dout, pf0_oe, pf0_dout, pf1_oe, pf1_dout, pin_din;
  logic [N-1:0] pin_oe, pin_dout, pf0_din, pf1_din, pin_od_cap;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [N-1:0] dir_m, mode_m;   // pin-indexed model

  always #2 clk = ~clk;

  pio_pin_mux u0 (
    .clk(clk), .hrst(hrst), .srst(srst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gpio_dout(gpio_dout), .pf0_oe(pf0_oe), .pf0_dout(pf0_dout),
    .pf1_oe(pf1_oe), .pf1_dout(pf1_dout), .pin_din(pin_din),
    .pin_oe(pin_oe), .pin_dout(pin_dout), .pf0_din(pf0_din),
    .pf1_din(pf1_din), .pin_od_cap(pin_od_cap)
  );

  function automatic logic [N-1:0] rev(input logic [N-1:0] v);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = v[N-1-i];
    return r;
  endfunction

  function automatic logic [N-1:0] exp_oe();
    logic [N-1:0] r;
    for (int p = 0; p < N; p++)
      r[p] = !mode_m[p] ? dir_m[p] : (dir_m[p] ? pf1_oe[p] : pf0_oe[p]);
    return r;
  endfunction

  function automatic logic [N-1:0] exp_do();
    logic [N-1:0] r;
    for (int p = 0; p < N; p++)
      r[p] = !mode_m[p] ? (dir_m[p] & gpio_dout[p])
                        : (dir_m[p] ? pf1_dout[p] : pf0_dout[p]);
    return r;
  endfunction

  function automatic logic [N-1:0] exp_f0();
    return mode_m & ~dir_m & pin_din;
  endfunction

  function automatic logic [N-1:0] exp_f1();
    return mode_m & dir_m & pin_din;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_pins(input string req);
    check(req, pin_oe, exp_oe());
    check(req, pin_dout, exp_do());
    check(req, pf0_din, exp_f0());
    check(req, pf1_din, exp_f1());
  endtask

  task automatic bus_idle();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  // drive at negedge, register updates at the following posedge
  task automatic wr(input logic [11:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    if (!hrst) begin
      if (a == A_DIR)  dir_m  = rev(d);
      if (a == A_MODE) mode_m = rev(d);
    end else begin
      dir_m = '0; mode_m = '0;
    end
    @(negedge clk);
    bus_idle();
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [N-1:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
    bus_idle();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    hrst = 1'b1; srst = 1'b0; bus_idle();
    gpio_dout = '0; pf0_oe = '0; pf0_dout = '0; pf1_oe = '0; pf1_dout = '0; pin_din = '0;
    dir_m = '0; mode_m = '0;
    repeat (3) @(negedge clk);
    hrst = 1'b0;

    // R1: reset state
    rd_check("R1 dir reset", A_DIR, '0);
    rd_check("R1 mode reset", A_MODE, '0);
    pin_din = 16'hFFFF; gpio_dout = 16'hFFFF; #1;
    check("R1 pins inputs", pin_oe, '0);
    check("R6 gpio grounds pf0", pf0_din, '0);

    // R10: open-drain mask
    check("R10 od mask", pin_od_cap, 16'h7FFF);

    // R7/R4: bus bit 15 (pin 0) as GPIO output
    wr(A_DIR, 16'h8000);
    #1;
    check("R7 pin0 oe", pin_oe, 16'h0001);
    check("R4 gpio out", pin_dout, 16'h0001);
    rd_check("R8 dir readback", A_DIR, 16'h8000);

    // R6: pin 15 dedicated fn0 then GPIO (receive grounded)
    wr(A_MODE, 16'h0001); wr(A_DIR, 16'h0000);
    pin_din = 16'h8000; #1;
    check("R6 pin15 fn0 in", pf0_din, 16'h8000);
    check("R6 fn1 unselected", pf1_din, '0);
    wr(A_MODE, 16'h0000); #1;
    check("R6 pin15 gpio grounds rx", pf0_din, '0);

    // R5: fn1 on all pins
    wr(A_MODE, 16'hFFFF); wr(A_DIR, 16'hFFFF);
    pf1_oe = 16'hA5C3; pf1_dout = 16'h3C5A; pf0_oe = 16'hFFFF; #1;
    check("R5 fn1 oe", pin_oe, 16'hA5C3);
    check("R5 fn1 dout", pin_dout, 16'h3C5A);

    // R9: stray write and read
    wr(12'h954, 16'h1234);
    rd_check("R9 stray write dir", A_DIR, 16'hFFFF);
    rd_check("R9 stray write mode", A_MODE, 16'hFFFF);
    rd_check("R9 unmapped read", 12'h954, '0);
    #1; check("R8 idle rdata", bus_rdata, '0);

    // R2: soft reset alone, then with a concurrent write
    @(negedge clk); srst = 1'b1; @(negedge clk); srst = 1'b0;
    rd_check("R2 srst keeps dir", A_DIR, 16'hFFFF);
    @(negedge clk); srst = 1'b1;
    wr(A_DIR, 16'h0F0F);
    srst = 1'b0;
    rd_check("R2 write with srst", A_DIR, 16'h0F0F);

    // R3: hard reset with concurrent write
    @(negedge clk); hrst = 1'b1;
    wr(A_MODE, 16'h5555);
    hrst = 1'b0;
    rd_check("R3 hrst beats write mode", A_MODE, '0);
    rd_check("R3 hrst clears dir", A_DIR, '0);

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [11:0] a;
      logic [N-1:0] d;
      @(negedge clk);
      gpio_dout = N'($urandom); pf0_oe = N'($urandom); pf0_dout = N'($urandom);
      pf1_oe = N'($urandom); pf1_dout = N'($urandom); pin_din = N'($urandom);
      srst = ($urandom % 4) == 0;
      op = $urandom % 4;
      a = (op == 0) ? A_DIR : (op == 1) ? A_MODE : (op == 2) ? 12'(12'h940 + ($urandom % 32)) : A_DIR;
      d = N'($urandom);
      bus_sel = 1'b1; bus_wr = (op != 3); bus_addr = a; bus_wdata = d;
      #1;
      check_pins("R4 R5 R6 random");
      if (op == 3) check("R8 random read", bus_rdata, rev(dir_m));
      @(posedge clk);
      if (bus_wr) begin
        if (a == A_DIR)  dir_m  = rev(d);
        if (a == A_MODE) mode_m = rev(d);
      end
    end
    @(negedge clk); bus_idle(); srst = 1'b0;
    rd_check("R2 R9 final mode", A_MODE, rev(mode_m));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule